// File: doc/BRIEF.md
# Operand Forwarding and Load Interlock Unit

This block holds the hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Operands are read only in decode and results are written only in writeback, so read-after-write is the only hazard it handles. Each cycle it compares the source register numbers of the instruction in decode with the destinations held in the decode/execute, execute/memory and memory/writeback pipeline registers. From that it decides how the instruction will get its operands. The selects for the two ALU operand multiplexers are computed one cycle early and registered, so they are valid during the instruction's execute cycle. A separate registered select steers the store-data multiplexer in the memory stage.

A load whose result is needed as an ALU operand by the very next instruction raises a one-cycle stall. The stall freezes the PC and the fetch/decode register, and the pipeline clears the write and memory-write controls entering decode/execute, which forms a bubble. A load whose result is needed only as the data of the store right behind it causes no stall: the loaded word is passed into the store's memory stage. Register zero never forwards and never stalls. Two decode-stage bypass flags also report same-cycle writeback collisions. A register file that does not write before it reads needs these flags, and one that does can leave them unconnected.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ex_sel_a, ex_sel_b and mem_sel_sd are 00.
- R2: A destination of register 0 never causes a stall, a non-00 select or a bypass flag, whatever its write-enable and load flag are.
- R3: Select codes are 00 for the register-file value, 01 for the execute/memory result and 10 for the memory/writeback result. Suppose a used source matches the destination of a writing non-load in decode/execute. Then the select in the following cycle is 01. If instead it matches only a writing instruction in execute/memory, that select is 10.
- R4: When a source matches both decode/execute and execute/memory destinations, the decode/execute (younger) producer decides the select.
- R5: stall is high in the same cycle when decode/execute holds a writing load whose non-zero destination equals id_rs with id_rs_used set, or id_rt with id_rt_used set. In the following cycle ex_sel_a and ex_sel_b are 00 (bubble).
- R6: If a store (id_is_store high, id_rt_used low) has its data register equal to the destination of a writing load in decode/execute, no stall is raised for that register. Two cycles later mem_sel_sd is 10. Otherwise mem_sel_sd is 00.
- R7: A store whose base register (id_rs, used) equals a load's destination in decode/execute is stalled exactly like an ALU use (R5).
- R8: A source whose used flag is low (id_rs_used, or for rt both id_rt_used and id_is_store) causes no stall and gives a 00 select.
- R9: id_byp_rs / id_byp_rt are high in the same cycle when memory/writeback writes a non-zero register equal to a used id_rs / id_rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | AW | First source register of the instruction in decode |
| id_rt | input | AW | Second source register of the instruction in decode |
| id_rs_used | input | 1 | id_rs is read as ALU operand A or address base |
| id_rt_used | input | 1 | id_rt is read as ALU operand B |
| id_is_store | input | 1 | Instruction in decode is a store, id_rt is its data |
| idex_rd | input | AW | Destination in decode/execute |
| idex_we | input | 1 | Decode/execute instruction writes a register |
| idex_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | AW | Destination in execute/memory |
| exmem_we | input | 1 | Execute/memory instruction writes a register |
| memwb_rd | input | AW | Destination in memory/writeback |
| memwb_we | input | 1 | Memory/writeback instruction writes a register |
| stall | output | 1 | Freeze PC and fetch/decode, bubble into decode/execute |
| ex_sel_a | output | 2 | ALU operand A source during execute |
| ex_sel_b | output | 2 | ALU operand B / store data source during execute |
| mem_sel_sd | output | 2 | Store-data source during memory stage |
| id_byp_rs | output | 1 | Decode read of id_rs collides with writeback |
| id_byp_rt | output | 1 | Decode read of id_rt collides with writeback |

## Verification
The bench aims at collisions on register 0 with write-enable and load flags set. A design that compared register numbers without the zero check would stall or forward garbage there. It sets up sources that match both older pipeline registers at once, where reversed priority picks a stale value. It drives load-then-store pairs that share only the data register: a design that lumped store data with ALU use would stall needlessly, and one with a short delay line would steer the memory-stage multiplexer a cycle early. It also drives loads feeding a store's base register, which must stall. Stalls must zero the registered selects, and a design that kept them would let the bubble drive forwarding paths.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;
   typedef enum logic [1:0] {
      SRC_RF    = 2'b00,
      SRC_EXMEM = 2'b01,
      SRC_MEMWB = 2'b10
   } fwd_src_e;
endpackage

// File: rtl/fwdu_cmp.sv
module fwdu_cmp #(
   parameter int AW = 5
) (
   input  logic          used,
   input  logic          we,
   input  logic [AW-1:0] dst,
   input  logic [AW-1:0] src,
   output logic          hit
);
   always_comb begin
      hit = used && we && (dst != '0) && (dst == src);
   end
endmodule

// File: rtl/fwdu_opsel.sv
module fwdu_opsel
   import fwdu_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic          used,
   input  logic          data_only,
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] idex_rd,
   input  logic          idex_we,
   input  logic          idex_load,
   input  logic [AW-1:0] exmem_rd,
   input  logic          exmem_we,
   output fwd_src_e      nxt_sel,
   output logic          load_hz,
   output logic          sd_req
);
   logic young_hit;
   logic old_hit;

   fwdu_cmp #(.AW(AW)) u_young (
      .used(used), .we(idex_we), .dst(idex_rd), .src(src), .hit(young_hit)
   );
   fwdu_cmp #(.AW(AW)) u_old (
      .used(used), .we(exmem_we), .dst(exmem_rd), .src(src), .hit(old_hit)
   );

   always_comb begin
      nxt_sel = SRC_RF;
      load_hz = 1'b0;
      sd_req  = 1'b0;
      if (young_hit) begin
         if (!idex_load)     nxt_sel = SRC_EXMEM;
         else if (data_only) sd_req  = 1'b1;
         else                load_hz = 1'b1;
      end else if (old_hit) begin
         nxt_sel = SRC_MEMWB;
      end
   end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwdu_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] id_rs,
   input  logic [AW-1:0] id_rt,
   input  logic          id_rs_used,
   input  logic          id_rt_used,
   input  logic          id_is_store,
   input  logic [AW-1:0] idex_rd,
   input  logic          idex_we,
   input  logic          idex_load,
   input  logic [AW-1:0] exmem_rd,
   input  logic          exmem_we,
   input  logic [AW-1:0] memwb_rd,
   input  logic          memwb_we,
   output logic          stall,
   output logic [1:0]    ex_sel_a,
   output logic [1:0]    ex_sel_b,
   output logic [1:0]    mem_sel_sd,
   output logic          id_byp_rs,
   output logic          id_byp_rt
);
   localparam int NOPS = 2;
   localparam int NREG = 1 << AW;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("fwd_hazard_unit: AW must be 1..8");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("fwd_hazard_unit: need at least two registers");
   end

   logic [AW-1:0] op_src   [NOPS];
   logic          op_used  [NOPS];
   logic          op_donly [NOPS];
   fwd_src_e      op_nxt   [NOPS];
   logic [NOPS-1:0] op_hz;
   logic [NOPS-1:0] op_sd;
   logic [NOPS-1:0] op_byp;

   always_comb begin
      op_src[0]   = id_rs;
      op_used[0]  = id_rs_used;
      op_donly[0] = 1'b0;
      op_src[1]   = id_rt;
      op_used[1]  = id_rt_used || id_is_store;
      op_donly[1] = id_is_store && !id_rt_used;
   end

   for (genvar g = 0; g < NOPS; g++) begin : g_op
      fwdu_opsel #(.AW(AW)) u_sel (
         .used      (op_used[g]),
         .data_only (op_donly[g]),
         .src       (op_src[g]),
         .idex_rd   (idex_rd),
         .idex_we   (idex_we),
         .idex_load (idex_load),
         .exmem_rd  (exmem_rd),
         .exmem_we  (exmem_we),
         .nxt_sel   (op_nxt[g]),
         .load_hz   (op_hz[g]),
         .sd_req    (op_sd[g])
      );
      fwdu_cmp #(.AW(AW)) u_wb (
         .used (op_used[g]),
         .we   (memwb_we),
         .dst  (memwb_rd),
         .src  (op_src[g]),
         .hit  (op_byp[g])
      );
   end

   logic     sd_pend_q;
   fwd_src_e sel_a_q;
   fwd_src_e sel_b_q;
   fwd_src_e sel_sd_q;

   always_comb begin
      stall = |op_hz;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_a_q   <= SRC_RF;
         sel_b_q   <= SRC_RF;
         sd_pend_q <= 1'b0;
         sel_sd_q  <= SRC_RF;
      end else begin
         sel_a_q   <= stall ? SRC_RF : op_nxt[0];
         sel_b_q   <= stall ? SRC_RF : op_nxt[1];
         sd_pend_q <= !stall && (|op_sd);
         sel_sd_q  <= sd_pend_q ? SRC_MEMWB : SRC_RF;
      end
   end

   assign ex_sel_a   = sel_a_q;
   assign ex_sel_b   = sel_b_q;
   assign mem_sel_sd = sel_sd_q;
   assign id_byp_rs  = op_byp[0];
   assign id_byp_rt  = op_byp[1];
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] id_rt,
   input logic          id_rt_used,
   input logic          id_is_store,
   input logic [AW-1:0] idex_rd,
   input logic          idex_we,
   input logic          idex_load,
   input logic          stall,
   input logic [1:0]    ex_sel_a,
   input logic [1:0]    ex_sel_b,
   input logic [1:0]    mem_sel_sd
);
   // R2
   stall_r0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_rd != '0));

   // R5
   stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_load && idex_we));

   // R5
   bubble_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

   // R3
   sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

   // R6
   sd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel_sd == 2'b00) || (mem_sel_sd == 2'b10));

   // R6
   sd_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_store && !id_rt_used && idex_load && idex_we &&
       idex_rd == id_rt && idex_rd != '0 && !stall) |=> ##1 (mem_sel_sd == 2'b10));
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_rt(id_rt), .id_rt_used(id_rt_used),
   .id_is_store(id_is_store), .idex_rd(idex_rd), .idex_we(idex_we),
   .idex_load(idex_load), .stall(stall), .ex_sel_a(ex_sel_a),
   .ex_sel_b(ex_sel_b), .mem_sel_sd(mem_sel_sd)
);

// File: tb/fwd_hazard_unit_bench.sv
module fwd_hazard_unit_bench;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] id_rs, id_rt, idex_rd, exmem_rd, memwb_rd;
   logic          id_rs_used, id_rt_used, id_is_store;
   logic          idex_we, idex_load, exmem_we, memwb_we;
   logic          stall, id_byp_rs, id_byp_rt;
   logic [1:0]    ex_sel_a, ex_sel_b, mem_sel_sd;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;

   // reference state: expected registered outputs
   int  e_sa = 0, e_sb = 0, e_sd = 0;
   bit  e_pend = 0;

   always #10 clk = ~clk;

   fwd_hazard_unit #(.AW(AW)) u_fwd_hazard_unit (
      .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
      .id_rs_used(id_rs_used), .id_rt_used(id_rt_used), .id_is_store(id_is_store),
      .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
      .exmem_rd(exmem_rd), .exmem_we(exmem_we), .memwb_rd(memwb_rd),
      .memwb_we(memwb_we), .stall(stall), .ex_sel_a(ex_sel_a),
      .ex_sel_b(ex_sel_b), .mem_sel_sd(mem_sel_sd),
      .id_byp_rs(id_byp_rs), .id_byp_rt(id_byp_rt)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural model of one operand: returns select, stall request, store request
   task automatic ref_op(input int src, input bit used, input bit data_only,
                         output int sel, output bit hz, output bit sdq);
      int y, o;
      sel = 0; hz = 0; sdq = 0;
      y = (idex_we  && int'(idex_rd)  != 0) ? int'(idex_rd)  : -1;
      o = (exmem_we && int'(exmem_rd) != 0) ? int'(exmem_rd) : -1;
      if (!used) return;
      if (src == y) begin
         if (idex_load == 1'b0) sel = 1;
         else if (data_only)    sdq = 1;
         else                   hz  = 1;
      end else if (src == o) begin
         sel = 2;
      end
   endtask

   task automatic drive(input int rs, input int rt, input bit ru, input bit tu, input bit st,
                        input int yd, input bit yw, input bit yl,
                        input int od, input bit ow, input int wd, input bit ww);
      id_rs = AW'(rs); id_rt = AW'(rt); id_rs_used = ru; id_rt_used = tu; id_is_store = st;
      idex_rd = AW'(yd); idex_we = yw; idex_load = yl;
      exmem_rd = AW'(od); exmem_we = ow; memwb_rd = AW'(wd); memwb_we = ww;
   endtask

   // One cycle: called after inputs settle, before the next posedge
   task automatic step_check(input string tag);
      int sa, sb, ea, eb;
      bit ha, hb, da, db, exp_stall;
      ref_op(int'(id_rs), id_rs_used, 1'b0, sa, ha, da);
      ref_op(int'(id_rt), id_rt_used || id_is_store, id_is_store && !id_rt_used, sb, hb, db);
      exp_stall = ha || hb;
      check({tag, " R5/R7 stall"}, int'(stall), int'(exp_stall));
      check({tag, " R3/R4 sel_a"}, int'(ex_sel_a), e_sa);
      check({tag, " R3/R4 sel_b"}, int'(ex_sel_b), e_sb);
      check({tag, " R6 sel_sd"}, int'(mem_sel_sd), e_sd);
      ea = (id_rs_used && memwb_we && memwb_rd != 0 && memwb_rd == id_rs) ? 1 : 0;
      eb = ((id_rt_used || id_is_store) && memwb_we && memwb_rd != 0 && memwb_rd == id_rt) ? 1 : 0;
      check({tag, " R9 byp_rs"}, int'(id_byp_rs), ea);
      check({tag, " R9 byp_rt"}, int'(id_byp_rt), eb);
      // advance reference registers as the clock edge will
      e_sd   = e_pend ? 2 : 0;
      e_pend = !exp_stall && db;
      e_sa   = exp_stall ? 0 : sa;
      e_sb   = exp_stall ? 0 : sb;
   endtask

   task automatic cyc(input string tag);
      #2;
      step_check(tag);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(1, 2, 1, 1, 0, 1, 1, 0, 2, 1, 0, 0);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 sel_a reset", int'(ex_sel_a), 0);
      check("R1 sel_b reset", int'(ex_sel_b), 0);
      check("R1 sel_sd reset", int'(mem_sel_sd), 0);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R1 first");

      // R3: ALU producer one ahead -> 01, two ahead -> 10
      drive(3, 4, 1, 1, 0, 3, 1, 0, 4, 1, 0, 0);
      cyc("R3 fwd");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R3 fwd res");
      // R4: both match, younger wins
      drive(5, 5, 1, 1, 0, 5, 1, 0, 5, 1, 0, 0);
      cyc("R4 prio");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R4 prio res");
      // R2: register 0 with all flags set
      drive(0, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 1);
      cyc("R2 zero");
      cyc("R2 zero res");
      // R5: load-use stall, then retry with load in EX/MEM
      drive(6, 1, 1, 0, 0, 6, 1, 1, 0, 0, 0, 0);
      cyc("R5 stall");
      drive(6, 1, 1, 0, 0, 0, 0, 0, 6, 1, 0, 0);
      cyc("R5 retry");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R5 res");
      // R6: load then store data only, no stall, sd=10 two cycles later
      drive(2, 7, 1, 0, 1, 7, 1, 1, 0, 0, 0, 0);
      cyc("R6 st");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R6 st+1");
      cyc("R6 st+2");
      cyc("R6 st+3");
      // R7: store base depends on load
      drive(7, 2, 1, 0, 1, 7, 1, 1, 0, 0, 0, 0);
      cyc("R7 base");
      // R8: unused sources ignored
      drive(8, 8, 0, 0, 0, 8, 1, 1, 8, 1, 8, 1);
      cyc("R8 unused");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R8 res");
      // R9: writeback collision
      drive(9, 10, 1, 1, 0, 0, 0, 0, 0, 0, 9, 1);
      cyc("R9 byp");
      drive(9, 10, 1, 1, 0, 0, 0, 0, 0, 0, 10, 1);
      cyc("R9 byp2");

      // random traffic over a small register window to force collisions
      for (int i = 0; i < 4000; i++) begin
         bit st, tu;
         st = ($urandom_range(0, 3) == 0);
         tu = st ? 1'b0 : 1'($urandom_range(0, 1));
         drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)), tu, st,
               $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)));
         cyc("rand R2");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule